// File: doc/BRIEF.md
# Daisy-Chain Configuration Shift Controller

This block loads a serial chain of up to seven identical chips from a word-addressed configuration memory. The bits that come back out of the end of the chain are captured into a readback memory. The host chooses a starting configuration set, the number of chips and a serial clock divider, and then pulses a start strobe. The controller reads each word from the configuration memory and shifts it out MSB first on a divided serial clock. It collects the returning bits and writes each finished word to the readback memory, at the same address the outgoing word came from. When the whole chain is done, it issues a one-cycle load pulse and returns to idle.

Each chip takes a block of 32 word slots, of which 25 are used. Slot 0 holds a 32-bit periphery word. Slots 1 to 24 hold pixel-pair words, and only the low 20 bits of these are used. The address is the 5-bit block number followed by the 5-bit slot number. The first chip shifted is the one at the selected block. Each following chip uses the next block number, and the block number wraps modulo 32.

Top module: `daisy_cfg_ctrl`

## Requirements
- R1: After reset, busy, serial clock, load, the configuration read enable and the readback write enable are all low.
- R2: A start strobe seen while idle raises busy on the next cycle. Busy stays high until the load pulse has been issued, that cycle included. A start strobe seen while busy has no effect on the transfer.
- R3: Within one chip, words go out in slot order 0, 1, …, 24. Slot 0 sends all 32 bits. Slots 1 to 24 send only bits 19..0. Every word is sent MSB first.
- R4: Chip k of the transfer (k = 0 is shifted first) reads address {(S + k) mod 32, slot}, where S is the 5-bit set select captured at start.
- R5: The transfer covers C chips, where C is the 3-bit chip count captured at start. A count of 0 means 6 chips. The transfer emits exactly C × 512 serial clock pulses.
- R6: Each serial clock high phase lasts exactly N system cycles, and each low phase lasts at least N. N is the 4-bit divider captured at start, and 0 is treated as 1. Data-out is stable while the serial clock is high.
- R7: Data-in is sampled on each serial clock rising edge. After the last bit of a word, the bits received during that word are written to the readback memory at that word's address, MSB first. Pixel words are zero-extended from 20 bits.
- R8: A single one-cycle load pulse follows the last bit of the chain. Busy then drops, and no further serial clock, read or write activity happens while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe (one cycle) |
| set_sel_i | input | 5 | First configuration block of the chain |
| chip_cnt_i | input | 3 | Number of chips in the chain, 0 means 6 |
| clk_div_i | input | 4 | Serial clock half period in system cycles, 0 means 1 |
| cfg_rd_en_o | output | 1 | Configuration memory read enable |
| cfg_rd_addr_o | output | 10 | Configuration memory address {block, slot} |
| cfg_rd_data_i | input | 32 | Configuration read data, one cycle after the enable |
| rb_wr_en_o | output | 1 | Readback memory write enable |
| rb_wr_addr_o | output | 10 | Readback memory address {block, slot} |
| rb_wr_data_o | output | 32 | Readback word |
| sclk_o | output | 1 | Serial clock to the chain |
| sdo_o | output | 1 | Serial data to the first chip |
| sdi_i | input | 1 | Serial data returning from the chain |
| load_o | output | 1 | One-cycle load pulse after the transfer |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench uses the default parameters: a 5-bit set select, 5-bit slot index, 25 slots per chip, 32-bit periphery and 20-bit pixel words, a 3-bit chip count with a default of 6, and a 4-bit divider. With these values the bench can reach the full seven-chip chain, the count-zero default, the wrap of block numbers past 31 and divider settings from the zero case up to 15. A start strobe injected mid-transfer shows that a busy block does not restart. A randomized return stream on data-in lets every readback word be compared bit for bit.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int DCC_SET_W     = 5;
  localparam int DCC_SLOT_W    = 5;
  localparam int DCC_SLOTS     = 25;
  localparam int DCC_WORD_W    = 32;
  localparam int DCC_PIX_W     = 20;
  localparam int DCC_CNT_W     = 3;
  localparam int DCC_DIV_W     = 4;
  localparam int DCC_DEF_CHIPS = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PRIME,
    ST_SHIFT,
    ST_LOAD
  } dcc_state_e;
endpackage

// File: rtl/dcc_sclk_gen.sv
module dcc_sclk_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;
  logic             ph_q, ph_d, term;

  assign lim  = half_i - DIV_W'(1);
  assign term = run_i && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!run_i) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign sclk_o = ph_q;
  assign rise_o = term && !ph_q;
  assign fall_o = term && ph_q;

  // R6: phase counter never passes the programmed half period
  assert_half_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < half_i));
endmodule

// File: rtl/dcc_addr_seq.sv
module dcc_addr_seq #(
  parameter int SET_W  = 5,
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 3,
  parameter int SLOTS  = 25
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init_i,
  input  logic [SET_W-1:0]        set_i,
  input  logic [CNT_W-1:0]        chips_i,
  input  logic                    step_i,
  output logic [SET_W+SLOT_W-1:0] addr_o,
  output logic                    first_slot_o,
  output logic                    last_o
);
  logic [SET_W-1:0]  blk_q, blk_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [CNT_W-1:0]  chip_q, chip_d, nch_q, nch_d;
  logic              slot_end;

  assign slot_end = (slot_q == SLOT_W'(SLOTS - 1));

  always_comb begin
    blk_d  = blk_q;
    slot_d = slot_q;
    chip_d = chip_q;
    nch_d  = nch_q;
    if (init_i) begin
      blk_d  = set_i;
      slot_d = '0;
      chip_d = '0;
      nch_d  = chips_i;
    end else if (step_i) begin
      if (slot_end) begin
        slot_d = '0;
        blk_d  = blk_q + SET_W'(1);
        chip_d = chip_q + CNT_W'(1);
      end else begin
        slot_d = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      slot_q <= '0;
      chip_q <= '0;
      nch_q  <= CNT_W'(1);
    end else begin
      blk_q  <= blk_d;
      slot_q <= slot_d;
      chip_q <= chip_d;
      nch_q  <= nch_d;
    end
  end

  assign addr_o       = {blk_q, slot_q};
  assign first_slot_o = (slot_q == '0);
  assign last_o       = slot_end && (chip_q == nch_q - CNT_W'(1));

  // R3: slot index stays inside the used part of a chip block
  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < SLOT_W'(SLOTS));
  // R5: the chip index never runs past the captured chain length
  assert_chip_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_i) |-> (chip_q < nch_q));
endmodule

// File: rtl/dcc_shifter.sv
module dcc_shifter #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              clear_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [WORD_W-1:0] rx_o,
  output logic              last_bit_o
);
  localparam int LEFT_W = $clog2(WORD_W + 1);
  localparam int PAD    = WORD_W - PIX_W;

  logic [WORD_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [LEFT_W-1:0] left_q, left_d;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    left_d = left_q;
    if (clear_i) begin
      tx_d   = '0;
      left_d = '0;
    end else if (load_i) begin
      tx_d   = wide_i ? word_i : (word_i << PAD);
      rx_d   = '0;
      left_d = wide_i ? LEFT_W'(WORD_W) : LEFT_W'(PIX_W);
    end else begin
      if (rise_i) rx_d = {rx_q[WORD_W-2:0], sdi_i};
      if (fall_i) begin
        tx_d   = {tx_q[WORD_W-2:0], 1'b0};
        left_d = left_q - LEFT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      left_q <= '0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      left_q <= left_d;
    end
  end

  assign sdo_o      = tx_q[WORD_W-1];
  assign rx_o       = rx_q;
  assign last_bit_o = (left_q == LEFT_W'(1));

  // R3: a falling edge only happens while bits remain in the word
  assert_no_underrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_i |-> (left_q != '0));
endmodule

// File: rtl/daisy_cfg_ctrl.sv
module daisy_cfg_ctrl
  import dcc_pkg::*;
#(
  parameter int SET_W     = DCC_SET_W,
  parameter int SLOT_W    = DCC_SLOT_W,
  parameter int SLOTS     = DCC_SLOTS,
  parameter int WORD_W    = DCC_WORD_W,
  parameter int PIX_W     = DCC_PIX_W,
  parameter int CNT_W     = DCC_CNT_W,
  parameter int DIV_W     = DCC_DIV_W,
  parameter int DEF_CHIPS = DCC_DEF_CHIPS,
  localparam int ADDR_W   = SET_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SET_W-1:0]  set_sel_i,
  input  logic [CNT_W-1:0]  chip_cnt_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  output logic              cfg_rd_en_o,
  output logic [ADDR_W-1:0] cfg_rd_addr_o,
  input  logic [WORD_W-1:0] cfg_rd_data_i,
  output logic              rb_wr_en_o,
  output logic [ADDR_W-1:0] rb_wr_addr_o,
  output logic [WORD_W-1:0] rb_wr_data_o,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i,
  output logic              load_o,
  output logic              busy_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1    <= 1'b1;
      rst_int_n <= rst_s1;
    end
  end

  dcc_state_e        state_q, state_d;
  logic [DIV_W-1:0]  div_q, div_d, div_eff;
  logic [CNT_W-1:0]  cnt_eff;
  logic              seq_init, seq_step, seq_first, seq_last;
  logic              sh_load, sh_clear, sh_last;
  logic              run, rise, fall;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] rx_word;

  assign div_eff = (clk_div_i == '0) ? DIV_W'(1) : clk_div_i;
  assign cnt_eff = (chip_cnt_i == '0) ? CNT_W'(DEF_CHIPS) : chip_cnt_i;

  always_comb begin
    state_d     = state_q;
    div_d       = div_q;
    seq_init    = 1'b0;
    seq_step    = 1'b0;
    sh_load     = 1'b0;
    sh_clear    = 1'b0;
    run         = 1'b0;
    cfg_rd_en_o = 1'b0;
    rb_wr_en_o  = 1'b0;
    load_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          seq_init = 1'b1;
          div_d    = div_eff;
          state_d  = ST_FETCH;
        end
      end
      ST_FETCH: begin
        cfg_rd_en_o = 1'b1;
        state_d     = ST_PRIME;
      end
      ST_PRIME: begin
        sh_load = 1'b1;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        run = 1'b1;
        if (fall && sh_last) begin
          rb_wr_en_o = 1'b1;
          seq_step   = 1'b1;
          state_d    = seq_last ? ST_LOAD : ST_FETCH;
        end
      end
      ST_LOAD: begin
        load_o   = 1'b1;
        sh_clear = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      div_q   <= DIV_W'(1);
    end else begin
      state_q <= state_d;
      if (seq_init) div_q <= div_d;
    end
  end

  dcc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (run),
    .half_i (div_q),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  dcc_addr_seq #(
    .SET_W  (SET_W),
    .SLOT_W (SLOT_W),
    .CNT_W  (CNT_W),
    .SLOTS  (SLOTS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .init_i       (seq_init),
    .set_i        (set_sel_i),
    .chips_i      (cnt_eff),
    .step_i       (seq_step),
    .addr_o       (addr),
    .first_slot_o (seq_first),
    .last_o       (seq_last)
  );

  dcc_shifter #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (sh_load),
    .wide_i     (seq_first),
    .word_i     (cfg_rd_data_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .clear_i    (sh_clear),
    .sdi_i      (sdi_i),
    .sdo_o      (sdo_o),
    .rx_o       (rx_word),
    .last_bit_o (sh_last)
  );

  assign cfg_rd_addr_o = addr;
  assign rb_wr_addr_o  = addr;
  assign rb_wr_data_o  = rx_word;
  assign busy_o        = (state_q != ST_IDLE);

  // R6: outgoing data holds while the serial clock is high
  assert_sdo_stable_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));
  // R8: the load pulse is one cycle and is followed by idle
  assert_load_ends_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_o |=> (!busy_o && !load_o));
  // R8: idle means no serial or memory activity
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> (!sclk_o && !rb_wr_en_o && !cfg_rd_en_o));
  // R2: load only happens inside a busy transfer
  assert_busy_load_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_o |-> busy_o);
  // R2: busy only rises after a start strobe
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy_o) |-> $past(start_i));
  // R7: readback writes land inside a used slot
  assert_rb_slot_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    rb_wr_en_o |-> (rb_wr_addr_o[SLOT_W-1:0] < SLOT_W'(SLOTS)));
endmodule

// File: tb/daisy_cfg_ctrl_bench.sv
module daisy_cfg_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [4:0]  set_sel;
  logic [2:0]  chip_cnt;
  logic [3:0]  clk_div;
  logic        cfg_rd_en;
  logic [9:0]  cfg_rd_addr;
  logic [31:0] cfg_rd_data;
  logic        rb_wr_en;
  logic [9:0]  rb_wr_addr;
  logic [31:0] rb_wr_data;
  logic        sclk, sdo, sdi, load, busy;

  always #5 clk = ~clk;

  daisy_cfg_ctrl u_daisy_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .set_sel_i(set_sel),
    .chip_cnt_i(chip_cnt), .clk_div_i(clk_div),
    .cfg_rd_en_o(cfg_rd_en), .cfg_rd_addr_o(cfg_rd_addr), .cfg_rd_data_i(cfg_rd_data),
    .rb_wr_en_o(rb_wr_en), .rb_wr_addr_o(rb_wr_addr), .rb_wr_data_o(rb_wr_data),
    .sclk_o(sclk), .sdo_o(sdo), .sdi_i(sdi), .load_o(load), .busy_o(busy)
  );

  int unsigned mem_seed;
  int          n_checks = 0;
  int          n_fail   = 0;

  function automatic logic [31:0] mem_word(input logic [9:0] a, input int unsigned s);
    return ({22'd0, a} * 32'h9E3779B1) ^ s ^ {a, 12'h5A5, a};
  endfunction

  always @(posedge clk) if (cfg_rd_en) cfg_rd_data <= mem_word(cfg_rd_addr, mem_seed);

  // monitor state
  logic        mon_clr = 1'b0;
  logic        sclk_prev;
  logic        got_sdo [0:4095];
  logic        got_sdi [0:4095];
  logic [31:0] rb_model [0:1023];
  int          nbits, hi_run, hi_bad, loads, late_act, rb_cnt;

  always @(negedge clk) begin
    if (!rst_n || mon_clr) begin
      nbits = 0; hi_run = 0; hi_bad = 0; loads = 0; late_act = 0; rb_cnt = 0;
      sclk_prev = 1'b0;
      sdi = 1'($urandom_range(0, 1));
      for (int i = 0; i < 1024; i++) rb_model[i] = 32'hDEAD_BEEF;
    end else begin
      if (sclk && !sclk_prev) begin
        if (nbits < 4096) begin got_sdo[nbits] = sdo; got_sdi[nbits] = sdi; end
        nbits++;
        if (loads > 0) late_act++;
      end
      if (sclk) hi_run++;
      if (!sclk && sclk_prev) begin
        if (hi_run != cur_half) hi_bad++;
        hi_run = 0;
        sdi = 1'($urandom_range(0, 1));
      end
      if (rb_wr_en) begin rb_model[rb_wr_addr] = rb_wr_data; rb_cnt++; end
      if (load) loads++;
      sclk_prev = sclk;
    end
  end

  int cur_half = 1;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [4:0] sel, input logic [2:0] cnt,
                          input logic [3:0] div, input bit inject);
    int ceff, neff, total, idx, bad3, bad4, bad7;
    logic [31:0] w, exp_rb;
    logic [9:0]  a;
    ceff = (cnt == 0) ? 6 : int'(cnt);
    neff = (div == 0) ? 1 : int'(div);
    cur_half = neff;
    mem_seed = $urandom;
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
    #1; set_sel = sel; chip_cnt = cnt; clk_div = div; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    set_sel = ~sel; chip_cnt = 3'd1; clk_div = 4'd7;
    @(negedge clk);
    chk(busy, "R2 busy after start", longint'(busy), 1);
    if (inject) begin
      repeat (60) @(posedge clk);
      #1; set_sel = sel + 5'd9; chip_cnt = 3'd2; clk_div = 4'd3; start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    total = ceff * 512;
    chk(nbits == total, "R5 serial clock pulses", nbits, total);
    bad3 = 0; bad4 = 0; bad7 = 0; idx = 0;
    for (int k = 0; k < ceff; k++) begin
      for (int s = 0; s < 25; s++) begin
        int wl;
        a  = {5'(sel + 5'(k)), 5'(s)};
        w  = mem_word(a, mem_seed);
        wl = (s == 0) ? 32 : 20;
        exp_rb = '0;
        for (int b = wl - 1; b >= 0; b--) begin
          if (idx < 4096) begin
            if (got_sdo[idx] !== w[b]) begin
              if (k == 0) bad3++; else bad4++;
            end
            exp_rb = {exp_rb[30:0], got_sdi[idx]};
          end
          idx++;
        end
        if (rb_model[a] !== exp_rb) bad7++;
      end
    end
    chk(bad3 == 0, "R3 first chip word stream", bad3, 0);
    chk(bad4 == 0, "R4 later chip block order", bad4, 0);
    chk(bad7 == 0, "R7 readback words", bad7, 0);
    chk(rb_cnt == ceff * 25, "R7 readback write count", rb_cnt, ceff * 25);
    chk(hi_bad == 0, "R6 high phase length", hi_bad, 0);
    chk(loads == 1, "R8 load pulse count", loads, 1);
    chk(late_act == 0 && !busy && !sclk, "R8 quiet after load", late_act, 0);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20151002));
    rst_n = 1'b0; start = 1'b0; set_sel = '0; chip_cnt = '0; clk_div = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !sclk && !load && !rb_wr_en && !cfg_rd_en, "R1 reset state",
        {busy, sclk, load, rb_wr_en, cfg_rd_en}, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    run_case(5'd0,  3'd1, 4'd0,  1'b0);  // R6 zero divider taken as 1
    run_case(5'd3,  3'd0, 4'd2,  1'b0);  // R5 count zero -> six chips
    run_case(5'd30, 3'd3, 4'd1,  1'b0);  // R4 block wrap past 31
    run_case(5'd10, 3'd7, 4'd1,  1'b1);  // R2 start while busy ignored, full chain
    run_case(5'd5,  3'd1, 4'd15, 1'b0);  // R6 largest divider
    for (int r = 0; r < 4; r++)
      run_case(5'($urandom_range(0, 31)), 3'($urandom_range(1, 3)),
               4'($urandom_range(1, 4)), 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule